// File: doc/BRIEF.md
# Bus-Based Instruction Fetch Sequencer

This block runs the instruction fetch phase of a small 16-bit processor over one shared internal bus. It holds a program counter, a memory address register, a memory data register and an instruction register. Two gated drivers (program counter or data register) place a word on the bus. A control state machine steps through a fixed five-step strobe sequence, so an instruction word moves from memory into the instruction register while the program counter advances.

The memory sits outside the block. It sees an enable, a read/write line (1 = read) and the address register. It returns read data one cycle after the enable is asserted. When a fetch completes, the block raises a one-cycle hand-off pulse for the decode stage and then waits for a start input before it begins the next fetch. Width, reset address, increment step and the bus implementation are parameters.

Top module: `fetch_seq_top`

## Requirements
- R1: A synchronous active-high reset loads the program counter with RESET_PC (default 0), clears the address, data and instruction registers, and puts the sequencer at step one. Step one is visible at the outputs in the first cycle after reset is released.
- R2: In step one, gate_pc and ld_mar are 1 and every other strobe is 0. The bus carries the program counter, and in the next cycle mem_addr equals that value.
- R3: In step two, mem_en and mem_rw are both 1 (read) and no gate or load strobe is active.
- R4: In step three, mem_en is 0 and ld_mdr is 1, so the word returned by memory is captured into the data register.
- R5: In step four, gate_mdr, ld_ir and ld_pc are 1 and pc_sel is 2'b00. The bus carries the captured word. In the next cycle ir equals that word and pc equals the old pc plus PC_STEP.
- R6: In step five, every gate, load and memory strobe is 0.
- R7: done is 1 for exactly one cycle, in the cycle after step five.
- R8: In every cycle, at most one of gate_pc and gate_mdr is 1. When neither is 1, the bus reads 0.
- R9: After done, the sequencer holds with all strobes 0 until start is 1. start being 1 in the done cycle or a waiting cycle gives step one in the next cycle. start has no effect during steps one to five.
- R10: The program counter wraps modulo 2^DATA_W (the value after all-ones plus one is 0).
- R11: pc_sel codes other than 2'b00 are reserved and hold the program counter. The sequencer only ever issues 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins the next fetch when the sequencer is waiting |
| mem_rdata | input | DATA_W | Read data, valid the cycle after a read enable |
| mem_en | output | 1 | Memory enable |
| mem_rw | output | 1 | 1 = read |
| mem_addr | output | DATA_W | Memory address register |
| bus | output | DATA_W | Shared internal bus |
| gate_pc | output | 1 | Program counter drives the bus |
| gate_mdr | output | 1 | Data register drives the bus |
| ld_mar | output | 1 | Address register load strobe |
| ld_mdr | output | 1 | Data register load strobe |
| ld_ir | output | 1 | Instruction register load strobe |
| ld_pc | output | 1 | Program counter load strobe |
| pc_sel | output | 2 | Next-PC source, 2'b00 = increment |
| pc | output | DATA_W | Program counter |
| ir | output | DATA_W | Instruction register |
| done | output | 1 | One-cycle fetch complete pulse |

## Verification
The bench builds the block with RESET_PC = 16'hFFFE and the AND-OR bus variant, which is the non-default variant. Starting near the top of the address space puts the program counter wrap of R10 inside the second fetch. The bench also exercises the bus build that plain elaboration with default parameters does not reach. With DATA_W left at 16 and PC_STEP at 1, every fetch reads a computed, address-dependent word. A mismatch in address capture, data capture or increment therefore shows up as a wrong ir or pc value.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

   typedef enum logic [2:0] {
      ST_ADDR  = 3'd0,
      ST_READ  = 3'd1,
      ST_CAPT  = 3'd2,
      ST_XFER  = 3'd3,
      ST_CLOSE = 3'd4,
      ST_DONE  = 3'd5,
      ST_IDLE  = 3'd6
   } fstep_t;

   typedef enum logic [1:0] {
      PCSEL_INC  = 2'b00,
      PCSEL_RSV1 = 2'b01,
      PCSEL_RSV2 = 2'b10,
      PCSEL_RSV3 = 2'b11
   } pcsel_t;

   typedef struct packed {
      logic   gate_pc;
      logic   gate_mdr;
      logic   ld_mar;
      logic   ld_mdr;
      logic   ld_ir;
      logic   ld_pc;
      logic   mem_en;
      logic   mem_rw;
      logic   done;
      pcsel_t pc_sel;
   } strobe_t;

   localparam strobe_t STROBE_IDLE = '{
      gate_pc: 1'b0, gate_mdr: 1'b0, ld_mar: 1'b0, ld_mdr: 1'b0,
      ld_ir: 1'b0, ld_pc: 1'b0, mem_en: 1'b0, mem_rw: 1'b0,
      done: 1'b0, pc_sel: PCSEL_INC};

endpackage

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
   import fetch_pkg::*;
(
   input  logic    clk,
   input  logic    rst,
   input  logic    start,
   output strobe_t strb
);

   fstep_t step_q, step_d;

   always_ff @(posedge clk) begin
      if (rst) step_q <= ST_ADDR;
      else     step_q <= step_d;
   end

   always_comb begin
      step_d = step_q;
      unique case (step_q)
         ST_ADDR:  step_d = ST_READ;
         ST_READ:  step_d = ST_CAPT;
         ST_CAPT:  step_d = ST_XFER;
         ST_XFER:  step_d = ST_CLOSE;
         ST_CLOSE: step_d = ST_DONE;
         ST_DONE:  step_d = start ? ST_ADDR : ST_IDLE;
         ST_IDLE:  step_d = start ? ST_ADDR : ST_IDLE;
         default:  step_d = ST_ADDR;
      endcase
   end

   always_comb begin
      strb = STROBE_IDLE;
      unique case (step_q)
         ST_ADDR: begin
            strb.gate_pc = 1'b1;
            strb.ld_mar  = 1'b1;
         end
         ST_READ: begin
            strb.mem_en = 1'b1;
            strb.mem_rw = 1'b1;
         end
         ST_CAPT: strb.ld_mdr = 1'b1;
         ST_XFER: begin
            strb.gate_mdr = 1'b1;
            strb.ld_ir    = 1'b1;
            strb.ld_pc    = 1'b1;
            strb.pc_sel   = PCSEL_INC;
         end
         ST_DONE: strb.done = 1'b1;
         default: strb = STROBE_IDLE;
      endcase
   end

endmodule

// File: rtl/fetch_bus.sv
module fetch_bus #(
   parameter int DATA_W     = 16,
   parameter bit BUS_AND_OR = 1'b0
) (
   input  logic [DATA_W-1:0] pc_val,
   input  logic [DATA_W-1:0] mdr_val,
   input  logic              gate_pc,
   input  logic              gate_mdr,
   output logic [DATA_W-1:0] bus
);

   generate
      if (BUS_AND_OR) begin : g_andor
         assign bus = (pc_val & {DATA_W{gate_pc}}) | (mdr_val & {DATA_W{gate_mdr}});
      end else begin : g_mux
         always_comb begin
            unique case ({gate_pc, gate_mdr})
               2'b10:   bus = pc_val;
               2'b01:   bus = mdr_val;
               default: bus = '0;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/fetch_regs.sv
module fetch_regs
   import fetch_pkg::*;
#(
   parameter int              DATA_W   = 16,
   parameter logic [DATA_W-1:0] RESET_PC = '0,
   parameter int              PC_STEP  = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  strobe_t           strb,
   input  logic [DATA_W-1:0] bus,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] pc_q,
   output logic [DATA_W-1:0] mar_q,
   output logic [DATA_W-1:0] mdr_q,
   output logic [DATA_W-1:0] ir_q
);

   localparam logic [DATA_W-1:0] STEP_V = DATA_W'(PC_STEP);

   logic [DATA_W-1:0] pc_next;

   always_comb begin
      unique case (strb.pc_sel)
         PCSEL_INC: pc_next = pc_q + STEP_V;
         default:   pc_next = pc_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q  <= RESET_PC;
         mar_q <= '0;
         mdr_q <= '0;
         ir_q  <= '0;
      end else begin
         if (strb.ld_pc)  pc_q  <= pc_next;
         if (strb.ld_mar) mar_q <= bus;
         if (strb.ld_mdr) mdr_q <= mem_rdata;
         if (strb.ld_ir)  ir_q  <= bus;
      end
   end

endmodule

// File: rtl/fetch_seq_top.sv
module fetch_seq_top
   import fetch_pkg::*;
#(
   parameter int              DATA_W     = 16,
   parameter logic [DATA_W-1:0] RESET_PC   = '0,
   parameter int              PC_STEP    = 1,
   parameter bit              BUS_AND_OR = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              mem_en,
   output logic              mem_rw,
   output logic [DATA_W-1:0] mem_addr,
   output logic [DATA_W-1:0] bus,
   output logic              gate_pc,
   output logic              gate_mdr,
   output logic              ld_mar,
   output logic              ld_mdr,
   output logic              ld_ir,
   output logic              ld_pc,
   output logic [1:0]        pc_sel,
   output logic [DATA_W-1:0] pc,
   output logic [DATA_W-1:0] ir,
   output logic              done
);

   generate
      if (DATA_W < 4) begin : g_bad_width
         $error("fetch_seq_top: DATA_W must be at least 4");
      end
      if (PC_STEP < 1) begin : g_bad_step
         $error("fetch_seq_top: PC_STEP must be positive");
      end
   endgenerate

   strobe_t           strb;
   logic [DATA_W-1:0] pc_q, mar_q, mdr_q, ir_q;

   fetch_ctrl u_ctrl (
      .clk   (clk),
      .rst   (rst),
      .start (start),
      .strb  (strb)
   );

   fetch_bus #(.DATA_W(DATA_W), .BUS_AND_OR(BUS_AND_OR)) u_bus (
      .pc_val   (pc_q),
      .mdr_val  (mdr_q),
      .gate_pc  (strb.gate_pc),
      .gate_mdr (strb.gate_mdr),
      .bus      (bus)
   );

   fetch_regs #(.DATA_W(DATA_W), .RESET_PC(RESET_PC), .PC_STEP(PC_STEP)) u_regs (
      .clk       (clk),
      .rst       (rst),
      .strb      (strb),
      .bus       (bus),
      .mem_rdata (mem_rdata),
      .pc_q      (pc_q),
      .mar_q     (mar_q),
      .mdr_q     (mdr_q),
      .ir_q      (ir_q)
   );

   assign mem_en   = strb.mem_en;
   assign mem_rw   = strb.mem_rw;
   assign mem_addr = mar_q;
   assign gate_pc  = strb.gate_pc;
   assign gate_mdr = strb.gate_mdr;
   assign ld_mar   = strb.ld_mar;
   assign ld_mdr   = strb.ld_mdr;
   assign ld_ir    = strb.ld_ir;
   assign ld_pc    = strb.ld_pc;
   assign pc_sel   = strb.pc_sel;
   assign pc       = pc_q;
   assign ir       = ir_q;
   assign done     = strb.done;

endmodule

// File: rtl/fetch_seq_chk.sv
module fetch_seq_chk #(
   parameter int DATA_W  = 16,
   parameter int PC_STEP = 1
) (
   input logic              clk,
   input logic              rst,
   input logic              mem_en,
   input logic              mem_rw,
   input logic [DATA_W-1:0] mem_addr,
   input logic [DATA_W-1:0] bus,
   input logic              gate_pc,
   input logic              gate_mdr,
   input logic              ld_mar,
   input logic              ld_mdr,
   input logic              ld_ir,
   input logic              ld_pc,
   input logic [1:0]        pc_sel,
   input logic [DATA_W-1:0] pc,
   input logic [DATA_W-1:0] ir,
   input logic              done
);

   // R8
   one_driver_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0({gate_pc, gate_mdr}));

   // R2
   mar_capture_chk: assert property (@(posedge clk) disable iff (rst)
      ld_mar |=> (mem_addr == $past(bus)));

   // R3
   read_follows_addr_chk: assert property (@(posedge clk) disable iff (rst)
      ld_mar |=> (mem_en && mem_rw && !ld_mar && !gate_pc));

   // R4
   capture_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
      mem_en |=> (ld_mdr && !mem_en));

   // R5
   ir_load_chk: assert property (@(posedge clk) disable iff (rst)
      ld_ir |=> (ir == $past(bus)));

   // R5
   pc_step_chk: assert property (@(posedge clk) disable iff (rst)
      (ld_pc && pc_sel == 2'b00) |=> (pc == $past(pc) + DATA_W'(PC_STEP)));

   // R6
   close_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      ld_ir |=> !(gate_pc || gate_mdr || ld_mar || ld_mdr || ld_ir || ld_pc || mem_en || done));

   // R7
   done_after_close_chk: assert property (@(posedge clk) disable iff (rst)
      ld_ir |=> ##1 done);

   // R7
   done_single_chk: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   // R11
   sel_inc_only_chk: assert property (@(posedge clk) disable iff (rst)
      ld_pc |-> (pc_sel == 2'b00));

endmodule

bind fetch_seq_top fetch_seq_chk #(.DATA_W(DATA_W), .PC_STEP(PC_STEP)) u_chk (
   .clk(clk), .rst(rst), .mem_en(mem_en), .mem_rw(mem_rw), .mem_addr(mem_addr),
   .bus(bus), .gate_pc(gate_pc), .gate_mdr(gate_mdr), .ld_mar(ld_mar),
   .ld_mdr(ld_mdr), .ld_ir(ld_ir), .ld_pc(ld_pc), .pc_sel(pc_sel),
   .pc(pc), .ir(ir), .done(done)
);

// File: tb/sim_fetch_seq_top.sv
`timescale 1ns/1ps
module sim_fetch_seq_top;

   localparam int          W     = 16;
   localparam logic [W-1:0] START = 16'hFFFE;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         start = 1'b0;
   logic [W-1:0] mem_rdata = '0;
   logic         mem_en, mem_rw, gate_pc, gate_mdr, ld_mar, ld_mdr, ld_ir, ld_pc, done;
   logic [W-1:0] mem_addr, bus, pc, ir;
   logic [1:0]   pc_sel;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   fetch_seq_top #(.DATA_W(W), .RESET_PC(START), .PC_STEP(1), .BUS_AND_OR(1'b1)) u0 (
      .clk(clk), .rst(rst), .start(start), .mem_rdata(mem_rdata),
      .mem_en(mem_en), .mem_rw(mem_rw), .mem_addr(mem_addr), .bus(bus),
      .gate_pc(gate_pc), .gate_mdr(gate_mdr), .ld_mar(ld_mar), .ld_mdr(ld_mdr),
      .ld_ir(ld_ir), .ld_pc(ld_pc), .pc_sel(pc_sel), .pc(pc), .ir(ir), .done(done)
   );

   function automatic logic [W-1:0] mem_word(input logic [W-1:0] a);
      logic [31:0] p;
      p = 32'(a) * 32'h9E37;
      return p[W-1:0] ^ 16'h2B1D;
   endfunction

   // synchronous memory: data one cycle after the read enable
   always @(posedge clk) if (mem_en && mem_rw) mem_rdata <= mem_word(mem_addr);

   // reference model: step 0..4 fetch steps, 5 done, 6 waiting
   int           m_step = 0;
   logic [W-1:0] m_pc = START, m_mar = '0, m_mdr = '0, m_ir = '0;

   always @(posedge clk) begin
      if (rst) begin
         m_step = 0; m_pc = START; m_mar = '0; m_mdr = '0; m_ir = '0;
      end else begin
         case (m_step)
            0: begin m_mar = m_pc; m_step = 1; end
            1: m_step = 2;
            2: begin m_mdr = mem_word(m_mar); m_step = 3; end
            3: begin m_ir = m_mdr; m_pc = m_pc + 16'd1; m_step = 4; end
            4: m_step = 5;
            default: m_step = start ? 0 : 6;
         endcase
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!finished) begin
         logic [W-1:0] ebus;
         logic [8:0]   got, exp;
         ebus = (m_step == 0) ? m_pc : (m_step == 3) ? m_mdr : '0;
         got = {gate_pc, gate_mdr, ld_mar, ld_mdr, ld_ir, ld_pc, mem_en, mem_rw, done};
         case (m_step)
            0: exp = 9'b1_0_1_0_0_0_0_0_0;
            1: exp = 9'b0_0_0_0_0_0_1_1_0;
            2: exp = 9'b0_0_0_1_0_0_0_0_0;
            3: exp = 9'b0_1_0_0_1_1_0_0_0;
            5: exp = 9'b0_0_0_0_0_0_0_0_1;
            default: exp = 9'b0;
         endcase
         // R2 R3 R4 R5 R6 R7 R9: strobe pattern per step
         case (m_step)
            0: chk(got == exp, "R2", "strobes", 32'(got), 32'(exp));
            1: chk(got == exp, "R3", "strobes", 32'(got), 32'(exp));
            2: chk(got == exp, "R4", "strobes", 32'(got), 32'(exp));
            3: chk(got == exp, "R5", "strobes", 32'(got), 32'(exp));
            4: chk(got == exp, "R6", "strobes", 32'(got), 32'(exp));
            5: chk(got == exp, "R7", "strobes", 32'(got), 32'(exp));
            default: chk(got == exp, "R9", "strobes", 32'(got), 32'(exp));
         endcase
         // R8 bus value and single driver
         chk(bus == ebus, "R8", "bus", 32'(bus), 32'(ebus));
         // R11 select code
         chk(pc_sel == 2'b00, "R11", "pc_sel", 32'(pc_sel), 32'd0);
         // R1 R10 program counter (covers reset and wrap)
         chk(pc == m_pc, rst ? "R1" : "R10", "pc", 32'(pc), 32'(m_pc));
         chk(mem_addr == m_mar, "R2", "mem_addr", 32'(mem_addr), 32'(m_mar));
         chk(ir == m_ir, "R5", "ir", 32'(ir), 32'(m_ir));
      end
   end

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic finish_run();
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #2_000_000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
   end

   initial begin
      cycles(3);
      rst = 1'b0;                 // R1: step one right after release
      cycles(12);                 // first fetch at FFFE, then wait (R9)
      start = 1'b1; cycles(1); start = 1'b0;
      cycles(10);                 // second fetch wraps FFFF -> 0 (R10)
      start = 1'b1; cycles(20);   // back-to-back fetches, start in done cycle
      start = 1'b0; cycles(10);
      start = 1'b1; cycles(1); start = 1'b0;
      cycles(2);
      start = 1'b1; cycles(1); start = 1'b0;   // mid-fetch start, no effect (R9)
      cycles(12);
      start = 1'b1; cycles(3);
      rst = 1'b1; cycles(2);      // reset in the middle of a fetch (R1)
      rst = 1'b0; start = 1'b0;
      cycles(15);
      finish_run();
   end

endmodule